// File: doc/BRIEF.md
# Two-Thread SMT Issue Arbiter

This block picks, every cycle, how many instructions each of two hardware threads may send into the issue stage of an in-order core that can issue two instructions per cycle. For each thread it receives the count of ready instructions at the head of that thread's queue. It also receives a flag that marks one thread as the critical one, and a flag that says whether both threads run the same parallel program. It returns a per-thread issue count for the current cycle.

The normal policy shares the slots. If both threads have work, each gets one slot. If only one thread has work, that thread may use both slots. When the two threads belong to the same parallel program, and the thread flagged critical has two ready instructions, the critical thread takes both slots and the other thread gets none. This lets the slowest thread catch up before the threads meet again.

The critical-thread flag passes through one register, so a new flag governs only from the next cycle. Everything else is combinational on the current inputs.

Top module: `smt_issue_arbiter`

## Requirements
- R1: After reset no thread is registered as critical. With both threads holding two ready instructions, each thread issues one, even if the critical-flag inputs were asserted during reset.
- R2: In every cycle, a thread never issues more than its clamped ready count, and the two issue counts sum to at most two.
- R3: When exactly one thread has a nonzero ready count, that thread issues its clamped ready count (1 or 2) and the other thread issues zero.
- R4: When both threads have nonzero ready counts and prioritization does not apply, each thread issues exactly one.
- R5: Prioritization applies when all three of these hold: the registered critical flag is set, same-program is high, and the registered critical thread (select 0 means thread 0, 1 means thread 1) has a clamped ready count of two. The critical thread then issues two and the other thread issues zero, whatever the other thread has ready.
- R6: When same-program is low, the base policy of R3/R4/R10 applies even with a registered critical thread.
- R7: A critical thread with only one ready instruction gets no priority. The base policy applies, so it issues one, and the other thread issues one if it has any ready.
- R8: The critical valid and select inputs are registered. A change on them affects the issue counts from the cycle after the clock edge that captures it, and not in the cycle it is presented.
- R9: A ready-count code of 3 is treated as 2, both for issuing and for the R5 condition.
- R10: When neither thread has ready instructions, both issue counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdy_t0_i | input | 2 | Ready instructions at head of thread 0 (3 counts as 2) |
| rdy_t1_i | input | 2 | Ready instructions at head of thread 1 (3 counts as 2) |
| same_app_i | input | 1 | Both threads belong to one parallel program |
| crit_valid_i | input | 1 | A critical thread is flagged |
| crit_sel_i | input | 1 | Which thread is critical (0 or 1) |
| issue_t0_o | output | 2 | Instructions issued from thread 0 this cycle |
| issue_t1_o | output | 2 | Instructions issued from thread 1 this cycle |

## Verification
The assertions check the following on every cycle:
- the slot budget and per-thread ready limits;
- single-thread grants, the one-each split and the priority grant, all against the registered critical state;
- that the registered flag follows its input one edge later.

Only the directed scenarios show the rest:
- the reset state, even with the critical inputs held high during reset;
- the exact cycle in which a changed critical flag starts and stops governing the grants;
- the clamping of code 3;
- that priority is withheld when the programs differ or when the critical thread has only one ready instruction.

// File: rtl/issue_arb_pkg.sv
`timescale 1ns/1ps
package issue_arb_pkg;
  localparam int ISSUE_WIDTH = 2;
  localparam int CNT_W       = $clog2(ISSUE_WIDTH + 2);
  localparam int NUM_THREADS = 2;

  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t CNT_ZERO = cnt_t'(0);
  localparam cnt_t CNT_ONE  = cnt_t'(1);
  localparam cnt_t CNT_FULL = cnt_t'(ISSUE_WIDTH);

  // Saturate a raw ready code at the issue width.
  function automatic cnt_t clamp_ready(input cnt_t raw);
    return (raw > CNT_FULL) ? CNT_FULL : raw;
  endfunction

  // Base sharing policy for one thread, given its own and the peer's ready count.
  function automatic cnt_t base_share(input cnt_t own, input cnt_t peer);
    if (own == CNT_ZERO)      return CNT_ZERO;
    else if (peer == CNT_ZERO) return own;
    else                       return cnt_t'(ISSUE_WIDTH / 2);
  endfunction
endpackage

// File: rtl/issue_crit_latch.sv
`timescale 1ns/1ps
module issue_crit_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic crit_valid_i,
  input  logic crit_sel_i,
  output logic crit_valid_q,
  output logic crit_sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit_valid_q <= 1'b0;
      crit_sel_q   <= 1'b0;
    end else begin
      crit_valid_q <= crit_valid_i;
      crit_sel_q   <= crit_sel_i;
    end
  end
endmodule

// File: rtl/issue_base_alloc.sv
`timescale 1ns/1ps
module issue_base_alloc
  import issue_arb_pkg::*;
(
  input  cnt_t rdy_c [NUM_THREADS],
  output cnt_t base_o [NUM_THREADS]
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    always_comb base_o[t] = base_share(rdy_c[t], rdy_c[NUM_THREADS-1-t]);
  end
endmodule

// File: rtl/issue_prio_select.sv
`timescale 1ns/1ps
module issue_prio_select
  import issue_arb_pkg::*;
(
  input  logic crit_valid_q,
  input  logic crit_sel_q,
  input  logic same_app_i,
  input  cnt_t rdy_c  [NUM_THREADS],
  input  cnt_t base_i [NUM_THREADS],
  output cnt_t issue_o [NUM_THREADS],
  output logic prio_hit_o
);
  cnt_t crit_rdy;

  always_comb begin
    crit_rdy   = rdy_c[crit_sel_q];
    prio_hit_o = crit_valid_q && same_app_i && (crit_rdy == CNT_FULL);
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    always_comb begin
      if (prio_hit_o)
        issue_o[t] = (crit_sel_q == 1'(t)) ? CNT_FULL : CNT_ZERO;
      else
        issue_o[t] = base_i[t];
    end
  end
endmodule

// File: rtl/smt_issue_arbiter.sv
`timescale 1ns/1ps
module smt_issue_arbiter
  import issue_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rdy_t0_i,
  input  logic [1:0] rdy_t1_i,
  input  logic       same_app_i,
  input  logic       crit_valid_i,
  input  logic       crit_sel_i,
  output logic [1:0] issue_t0_o,
  output logic [1:0] issue_t1_o
);
  logic crit_valid_q;
  logic crit_sel_q;
  logic prio_hit;
  cnt_t rdy_raw [NUM_THREADS];
  cnt_t rdy_c   [NUM_THREADS];
  cnt_t base    [NUM_THREADS];
  cnt_t issue   [NUM_THREADS];

  always_comb begin
    rdy_raw[0] = cnt_t'(rdy_t0_i);
    rdy_raw[1] = cnt_t'(rdy_t1_i);
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_clamp
    always_comb rdy_c[t] = clamp_ready(rdy_raw[t]);
  end

  issue_crit_latch u_latch (
    .clk          (clk),
    .rst_n        (rst_n),
    .crit_valid_i (crit_valid_i),
    .crit_sel_i   (crit_sel_i),
    .crit_valid_q (crit_valid_q),
    .crit_sel_q   (crit_sel_q)
  );

  issue_base_alloc u_base (
    .rdy_c  (rdy_c),
    .base_o (base)
  );

  issue_prio_select u_prio (
    .crit_valid_q (crit_valid_q),
    .crit_sel_q   (crit_sel_q),
    .same_app_i   (same_app_i),
    .rdy_c        (rdy_c),
    .base_i       (base),
    .issue_o      (issue),
    .prio_hit_o   (prio_hit)
  );

  always_comb begin
    issue_t0_o = 2'(issue[0]);
    issue_t1_o = 2'(issue[1]);
  end
endmodule

// File: rtl/smt_issue_arbiter_chk.sv
`timescale 1ns/1ps
module smt_issue_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rdy_t0_i,
  input logic [1:0] rdy_t1_i,
  input logic       same_app_i,
  input logic       crit_valid_i,
  input logic       crit_sel_i,
  input logic [1:0] issue_t0_o,
  input logic [1:0] issue_t1_o,
  input logic       crit_valid_q,
  input logic       crit_sel_q
);
  logic       armed;
  logic [1:0] r0, r1, crit_r;
  logic       prio_cond;

  always_comb begin
    r0        = (rdy_t0_i == 2'd3) ? 2'd2 : rdy_t0_i;
    r1        = (rdy_t1_i == 2'd3) ? 2'd2 : rdy_t1_i;
    crit_r    = crit_sel_q ? r1 : r0;
    prio_cond = crit_valid_q && same_app_i && (crit_r == 2'd2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2
  slot_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, issue_t0_o} + {1'b0, issue_t1_o} <= 3'd2) && (issue_t0_o <= r0) && (issue_t1_o <= r1));

  // R3
  lone_t0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r0 != 2'd0 && r1 == 2'd0) |-> (issue_t0_o == r0 && issue_t1_o == 2'd0));

  // R3
  lone_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r1 != 2'd0 && r0 == 2'd0) |-> (issue_t1_o == r1 && issue_t0_o == 2'd0));

  // R4
  even_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r0 != 2'd0 && r1 != 2'd0 && !prio_cond) |-> (issue_t0_o == 2'd1 && issue_t1_o == 2'd1));

  // R5
  prio_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prio_cond |-> (crit_sel_q ? (issue_t1_o == 2'd2 && issue_t0_o == 2'd0)
                              : (issue_t0_o == 2'd2 && issue_t1_o == 2'd0)));

  // R8
  crit_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (crit_valid_q == $past(crit_valid_i)
               && (!crit_valid_q || crit_sel_q == $past(crit_sel_i))));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r0 == 2'd0 && r1 == 2'd0) |-> (issue_t0_o == 2'd0 && issue_t1_o == 2'd0));
endmodule

bind smt_issue_arbiter smt_issue_arbiter_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .rdy_t0_i     (rdy_t0_i),
  .rdy_t1_i     (rdy_t1_i),
  .same_app_i   (same_app_i),
  .crit_valid_i (crit_valid_i),
  .crit_sel_i   (crit_sel_i),
  .issue_t0_o   (issue_t0_o),
  .issue_t1_o   (issue_t1_o),
  .crit_valid_q (crit_valid_q),
  .crit_sel_q   (crit_sel_q)
);

// File: tb/smt_issue_arbiter_tb_top.sv
`timescale 1ns/1ps
module smt_issue_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rdy_t0 = 2'd0, rdy_t1 = 2'd0;
  logic       same_app = 1'b0, crit_valid = 1'b0, crit_sel = 1'b0;
  logic [1:0] issue_t0, issue_t1;
  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  smt_issue_arbiter dut_i (
    .clk (clk), .rst_n (rst_n),
    .rdy_t0_i (rdy_t0), .rdy_t1_i (rdy_t1),
    .same_app_i (same_app), .crit_valid_i (crit_valid), .crit_sel_i (crit_sel),
    .issue_t0_o (issue_t0), .issue_t1_o (issue_t1)
  );

  task automatic check(input string req, input logic [1:0] e0, input logic [1:0] e1);
    tests++;
    if (issue_t0 !== e0 || issue_t1 !== e1) begin
      fails++;
      $display("FAIL %s: got t0=%0d t1=%0d expected t0=%0d t1=%0d", req, issue_t0, issue_t1, e0, e1);
    end
  endtask

  // Drive ready counts at a falling edge and sample 1 ns later, before the rising edge.
  task automatic apply(input logic [1:0] a, input logic [1:0] b, input logic sa);
    @(negedge clk);
    rdy_t0 = a; rdy_t1 = b; same_app = sa;
    #1;
  endtask

  // Present a critical flag and let one rising edge capture it.
  task automatic set_crit(input logic v, input logic s);
    @(negedge clk);
    crit_valid = v; crit_sel = s;
    @(posedge clk);
  endtask

  task automatic sc_reset();
    crit_valid = 1'b1; crit_sel = 1'b0; same_app = 1'b1;
    rdy_t0 = 2'd2; rdy_t1 = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 reset clears critical", 2'd1, 2'd1);
    set_crit(1'b0, 1'b0);
  endtask

  task automatic sc_single();
    apply(2'd2, 2'd0, 1'b1); check("R3 t0 alone two", 2'd2, 2'd0);
    apply(2'd1, 2'd0, 1'b1); check("R3 t0 alone one", 2'd1, 2'd0);
    apply(2'd0, 2'd2, 1'b0); check("R3 t1 alone two", 2'd0, 2'd2);
    apply(2'd0, 2'd3, 1'b0); check("R9 code three as two", 2'd0, 2'd2);
    apply(2'd0, 2'd0, 1'b1); check("R10 none ready", 2'd0, 2'd0);
  endtask

  task automatic sc_base();
    apply(2'd1, 2'd1, 1'b1); check("R4 one each", 2'd1, 2'd1);
    apply(2'd2, 2'd1, 1'b1); check("R4 two and one", 2'd1, 2'd1);
    apply(2'd2, 2'd2, 1'b1); check("R4 no critical", 2'd1, 2'd1);
  endtask

  task automatic sc_prio();
    set_crit(1'b1, 1'b1);
    apply(2'd2, 2'd2, 1'b1); check("R5 critical t1 takes both", 2'd0, 2'd2);
    apply(2'd1, 2'd2, 1'b1); check("R5 other one ready", 2'd0, 2'd2);
    apply(2'd3, 2'd3, 1'b1); check("R9 clamped priority", 2'd0, 2'd2);
  endtask

  task automatic sc_crit_one();
    apply(2'd2, 2'd1, 1'b1); check("R7 critical one ready", 2'd1, 2'd1);
    apply(2'd0, 2'd1, 1'b1); check("R7 critical one alone", 2'd0, 2'd1);
  endtask

  task automatic sc_app();
    set_crit(1'b1, 1'b0);
    apply(2'd2, 2'd2, 1'b0); check("R6 different programs", 2'd1, 2'd1);
    apply(2'd2, 2'd2, 1'b1); check("R5 critical t0 takes both", 2'd2, 2'd0);
  endtask

  task automatic sc_timing();
    set_crit(1'b1, 1'b1);
    @(negedge clk);
    rdy_t0 = 2'd2; rdy_t1 = 2'd2; same_app = 1'b1;
    crit_sel = 1'b0;
    #1 check("R8 old select still governs", 2'd0, 2'd2);
    @(posedge clk); #1 check("R8 new select after edge", 2'd2, 2'd0);
    @(negedge clk);
    crit_valid = 1'b0;
    #1 check("R8 old valid still governs", 2'd2, 2'd0);
    @(posedge clk); #1 check("R8 cleared after edge", 2'd1, 2'd1);
  endtask

  task automatic sc_sweep();
    set_crit(1'b1, 1'b0);
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        apply(2'(a), 2'(b), 1'b1);
        tests++;
        if ((int'(issue_t0) + int'(issue_t1) > 2) || (int'(issue_t0) > (a > 2 ? 2 : a))
            || (int'(issue_t1) > (b > 2 ? 2 : b))) begin
          fails++;
          $display("FAIL R2 sweep a=%0d b=%0d: got t0=%0d t1=%0d expected within budget",
                   a, b, issue_t0, issue_t1);
        end
      end
    end
  endtask

  initial begin
    sc_reset();
    sc_single();
    sc_base();
    sc_prio();
    sc_crit_one();
    sc_app();
    sc_timing();
    sc_sweep();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule